// File: doc/BRIEF.md
# Conversion Result Byte Latch with Read Coherence Lock

This block keeps the most recent 10-bit converter result and lays it out as two bytes for an 8-bit processor bus. A justification input chooses whether the value sits at the bottom of the 16-bit pair, which is the default, or at the top. Software that needs the full value reads the low byte first and the high byte second. Reading the low byte engages a lock, so a result that finishes between the two reads cannot tear the pair.

While the lock is engaged, any result that arrives is thrown away and both bytes keep their contents. The completion pulse still fires, so the interrupt path sees every conversion, including the ones that were lost. Reading the high byte releases the lock. A read of only the high byte is harmless when nothing is locked. Changing the justification input re-presents the stored value at once, with no new conversion needed.

Top module: `adc_result_lock`

## Requirements
- R1: With the justification input low, the high byte carries result bits 9:8 in its bits 1:0 with bits 7:2 zero, and the low byte carries result bits 7:0.
- R2: With the justification input high, the high byte carries result bits 9:2, low byte bits 7:6 carry result bits 1:0, and low byte bits 5:0 are zero.
- R3: A low-byte read strobe without a high-byte read strobe in the same cycle engages the lock from the next cycle on.
- R4: A result strobe that arrives while the lock is engaged is discarded, and neither byte changes.
- R5: A high-byte read strobe releases the lock from the next cycle on, including when it coincides with a low-byte read strobe, so a result strobe in the following cycle is stored.
- R6: The completion output is high for exactly the one cycle after each result strobe, whether the result was stored or discarded.
- R7: A high-byte read with no low-byte read before it leaves the block unlocked, and the next result is stored.
- R8: A change of the justification input changes both output bytes in the same cycle, with no result strobe.
- R9: A result strobe in the same cycle as a low-byte read strobe is discarded.
- R10: After reset both bytes read zero, the completion output is low and the block is unlocked.
- R11: When unlocked, a result strobe stores its value, and the value shows on the bytes from the cycle after the strobe.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| res_vld_i | input | 1 | One-cycle strobe: a new result is on res_i |
| res_i | input | 10 | Conversion result value |
| fmt_left_i | input | 1 | 1 = left-justified layout, 0 = right-justified layout |
| rd_lo_i | input | 1 | One-cycle strobe: the bus reads the low byte |
| rd_hi_i | input | 1 | One-cycle strobe: the bus reads the high byte |
| lo_byte_o | output | 8 | Low byte as presented to the bus |
| hi_byte_o | output | 8 | High byte as presented to the bus |
| done_o | output | 1 | Completion pulse, one cycle after each result strobe |

## Verification
The assertions assume that each strobe lasts one clock cycle and that inputs change only between clock edges. They also assume the justification input stays steady across a store whenever a check compares the stored value with the output bytes. The bench drives every input on the falling clock edge and lowers each strobe one cycle later. It changes justification only while no result strobe is active. It also fires the lock, release and result strobes in the same cycle, so the assertions see the priority corners as well as the simple cases.

// File: rtl/adc_lock_pkg.sv
package adc_lock_pkg;

  typedef enum logic {
    JUST_RIGHT = 1'b0,
    JUST_LEFT  = 1'b1
  } just_e;

  typedef enum logic {
    LK_OPEN = 1'b0,
    LK_HELD = 1'b1
  } lock_e;

endpackage

// File: rtl/arl_rst_sync.sv
module arl_rst_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  output logic rst_sn
);
  logic [STAGES-1:0] chain_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) chain_q <= '0;
    else        chain_q <= {chain_q[STAGES-2:0], 1'b1};
  end

  assign rst_sn = chain_q[STAGES-1];
endmodule

// File: rtl/arl_lock_ctrl.sv
module arl_lock_ctrl
  import adc_lock_pkg::*;
(
  input  logic clk,
  input  logic rst_sn,
  input  logic res_vld_i,
  input  logic rd_lo_i,
  input  logic rd_hi_i,
  output logic accept_o,
  output logic held_o
);
  lock_e state_q, state_d;

  // high read wins over a coincident low read
  always_comb begin
    state_d = state_q;
    if (rd_hi_i)      state_d = LK_OPEN;
    else if (rd_lo_i) state_d = LK_HELD;
  end

  always_ff @(posedge clk or negedge rst_sn) begin
    if (!rst_sn) state_q <= LK_OPEN;
    else         state_q <= state_d;
  end

  // a result landing with a low read would tear the pair in flight
  assign accept_o = res_vld_i && (state_q == LK_OPEN) && !rd_lo_i;
  assign held_o   = (state_q == LK_HELD);
endmodule

// File: rtl/arl_result_store.sv
module arl_result_store #(
  parameter int RES_W = 10
) (
  input  logic             clk,
  input  logic             rst_sn,
  input  logic             wr_en_i,
  input  logic [RES_W-1:0] wr_data_i,
  output logic [RES_W-1:0] data_o
);
  logic [RES_W-1:0] data_q, data_d;

  always_comb begin
    data_d = data_q;
    if (wr_en_i) data_d = wr_data_i;
  end

  always_ff @(posedge clk or negedge rst_sn) begin
    if (!rst_sn) data_q <= '0;
    else         data_q <= data_d;
  end

  assign data_o = data_q;
endmodule

// File: rtl/arl_byte_fmt.sv
module arl_byte_fmt
  import adc_lock_pkg::*;
#(
  parameter int RES_W = 10,
  parameter int BUS_W = 8
) (
  input  logic [RES_W-1:0] res_i,
  input  just_e            just_i,
  output logic [BUS_W-1:0] lo_o,
  output logic [BUS_W-1:0] hi_o
);
  localparam int HI_W  = RES_W - BUS_W;
  localparam int PAD_W = 2*BUS_W - RES_W;

  logic [2*BUS_W-1:0] word;

  always_comb begin
    case (just_i)
      JUST_LEFT: word = {res_i, {PAD_W{1'b0}}};
      default:   word = {{PAD_W{1'b0}}, res_i};
    endcase
    lo_o = word[BUS_W-1:0];
    hi_o = word[2*BUS_W-1:BUS_W];
  end

  if (HI_W < 1 || PAD_W < 0) begin : g_bad_widths
    initial $error("arl_byte_fmt: need BUS_W < RES_W <= 2*BUS_W");
  end
endmodule

// File: rtl/adc_result_lock.sv
module adc_result_lock
  import adc_lock_pkg::*;
#(
  parameter int RES_W = 10,
  parameter int BUS_W = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             res_vld_i,
  input  logic [RES_W-1:0] res_i,
  input  logic             fmt_left_i,
  input  logic             rd_lo_i,
  input  logic             rd_hi_i,
  output logic [BUS_W-1:0] lo_byte_o,
  output logic [BUS_W-1:0] hi_byte_o,
  output logic             done_o
);
  logic             rst_sn;
  logic             accept;
  logic             lock_held;
  logic [RES_W-1:0] res_q;
  logic             done_q, done_d;
  just_e            just;

  arl_rst_sync #(.STAGES(2)) u_rst (
    .clk(clk), .rst_n(rst_n), .rst_sn(rst_sn)
  );

  arl_lock_ctrl u_lock (
    .clk(clk), .rst_sn(rst_sn), .res_vld_i(res_vld_i),
    .rd_lo_i(rd_lo_i), .rd_hi_i(rd_hi_i),
    .accept_o(accept), .held_o(lock_held)
  );

  arl_result_store #(.RES_W(RES_W)) u_store (
    .clk(clk), .rst_sn(rst_sn), .wr_en_i(accept),
    .wr_data_i(res_i), .data_o(res_q)
  );

  assign just = fmt_left_i ? JUST_LEFT : JUST_RIGHT;

  arl_byte_fmt #(.RES_W(RES_W), .BUS_W(BUS_W)) u_fmt (
    .res_i(res_q), .just_i(just), .lo_o(lo_byte_o), .hi_o(hi_byte_o)
  );

  // completion pulse follows every strobe, stored or not
  always_comb done_d = res_vld_i;

  always_ff @(posedge clk or negedge rst_sn) begin
    if (!rst_sn) done_q <= 1'b0;
    else         done_q <= done_d;
  end

  assign done_o = done_q;
endmodule

// File: rtl/arl_chk.sv
module arl_chk #(
  parameter int RES_W = 10,
  parameter int BUS_W = 8
) (
  input logic             clk,
  input logic             rst_sn,
  input logic             res_vld_i,
  input logic [RES_W-1:0] res_i,
  input logic             fmt_left_i,
  input logic             rd_lo_i,
  input logic             rd_hi_i,
  input logic [BUS_W-1:0] lo_byte_o,
  input logic [BUS_W-1:0] hi_byte_o,
  input logic             done_o,
  input logic             lock_held,
  input logic [RES_W-1:0] res_q
);
  localparam int HI_W  = RES_W - BUS_W;
  localparam int PAD_W = 2*BUS_W - RES_W;

  p_right_pad_r1: assert property (@(posedge clk) disable iff (!rst_sn)
    !fmt_left_i |-> hi_byte_o[BUS_W-1:HI_W] == '0);

  p_left_pad_r2: assert property (@(posedge clk) disable iff (!rst_sn)
    fmt_left_i |-> lo_byte_o[PAD_W-1:0] == '0);

  p_lock_on_r3: assert property (@(posedge clk) disable iff (!rst_sn)
    (rd_lo_i && !rd_hi_i) |=> lock_held);

  p_discard_r4: assert property (@(posedge clk) disable iff (!rst_sn)
    (res_vld_i && lock_held) |=> $stable(res_q));

  p_release_r5: assert property (@(posedge clk) disable iff (!rst_sn)
    rd_hi_i |=> !lock_held);

  p_lock_hold_r3: assert property (@(posedge clk) disable iff (!rst_sn)
    (!rd_lo_i && !rd_hi_i) |=> $stable(lock_held));

  p_done_r6: assert property (@(posedge clk) disable iff (!rst_sn)
    res_vld_i |=> done_o);

  p_no_done_r6: assert property (@(posedge clk) disable iff (!rst_sn)
    !res_vld_i |=> !done_o);

  p_same_cycle_r9: assert property (@(posedge clk) disable iff (!rst_sn)
    (res_vld_i && rd_lo_i) |=> $stable(res_q));

  p_accept_r11: assert property (@(posedge clk) disable iff (!rst_sn)
    (res_vld_i && !lock_held && !rd_lo_i && !fmt_left_i) |=>
      (fmt_left_i || {hi_byte_o[HI_W-1:0], lo_byte_o} == $past(res_i)));
endmodule

bind adc_result_lock arl_chk #(.RES_W(RES_W), .BUS_W(BUS_W)) u_chk (
  .clk(clk), .rst_sn(rst_sn), .res_vld_i(res_vld_i), .res_i(res_i),
  .fmt_left_i(fmt_left_i), .rd_lo_i(rd_lo_i), .rd_hi_i(rd_hi_i),
  .lo_byte_o(lo_byte_o), .hi_byte_o(hi_byte_o), .done_o(done_o),
  .lock_held(lock_held), .res_q(res_q)
);

// File: tb/sim_adc_result_lock.sv
`timescale 1ns/1ps
module sim_adc_result_lock;
  logic       clk = 1'b0;
  logic       rst_n;
  logic       res_vld_i, fmt_left_i, rd_lo_i, rd_hi_i;
  logic [9:0] res_i;
  logic [7:0] lo_byte_o, hi_byte_o;
  logic       done_o;

  int total = 0;
  int bad   = 0;
  logic [9:0] shadow;  // value the bench expects stored

  always #10 clk = ~clk;

  adc_result_lock u0 (
    .clk(clk), .rst_n(rst_n), .res_vld_i(res_vld_i), .res_i(res_i),
    .fmt_left_i(fmt_left_i), .rd_lo_i(rd_lo_i), .rd_hi_i(rd_hi_i),
    .lo_byte_o(lo_byte_o), .hi_byte_o(hi_byte_o), .done_o(done_o)
  );

  function automatic logic [15:0] pair(input logic [9:0] v, input logic left);
    return left ? {v, 6'b000000} : {6'b000000, v};
  endfunction

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic chk_bytes(input string req);
    chk(req, {16'h0, hi_byte_o, lo_byte_o}, {16'h0, pair(shadow, fmt_left_i)});
  endtask

  // strobe for one cycle; sampled at the next falling edge
  task automatic strobe(input logic vld, input logic [9:0] v, input logic lo, input logic hi);
    @(negedge clk);
    res_vld_i = vld; res_i = v; rd_lo_i = lo; rd_hi_i = hi;
    @(negedge clk);
    res_vld_i = 1'b0; rd_lo_i = 1'b0; rd_hi_i = 1'b0;
  endtask

  task automatic t_reset();
    chk("R10 lo", {24'h0, lo_byte_o}, 32'h0);
    chk("R10 hi", {24'h0, hi_byte_o}, 32'h0);
    chk("R10 done", {31'h0, done_o}, 32'h0);
    strobe(1'b1, 10'h0C3, 1'b0, 1'b0);
    shadow = 10'h0C3;
    chk_bytes("R10 unlocked after reset");
  endtask

  task automatic t_right();
    fmt_left_i = 1'b0;
    strobe(1'b1, 10'h2A5, 1'b0, 1'b0);
    chk("R6 done after store", {31'h0, done_o}, 32'h1);
    shadow = 10'h2A5;
    chk("R1 R11 hi", {24'h0, hi_byte_o}, 32'h02);
    chk("R1 R11 lo", {24'h0, lo_byte_o}, 32'hA5);
    @(negedge clk);
    chk("R6 single cycle", {31'h0, done_o}, 32'h0);
  endtask

  task automatic t_left();
    fmt_left_i = 1'b1;
    #1;
    chk("R2 R8 hi", {24'h0, hi_byte_o}, 32'hA9);
    chk("R2 R8 lo", {24'h0, lo_byte_o}, 32'h40);
    fmt_left_i = 1'b0;
    #1;
    chk_bytes("R8 back to right");
  endtask

  task automatic t_lock();
    strobe(1'b0, 10'h0, 1'b1, 1'b0);
    strobe(1'b1, 10'h155, 1'b0, 1'b0);
    chk("R6 done when discarded", {31'h0, done_o}, 32'h1);
    chk_bytes("R3 R4 discard under lock");
    strobe(1'b1, 10'h0FF, 1'b0, 1'b0);
    chk_bytes("R4 second discard");
    strobe(1'b0, 10'h0, 1'b0, 1'b1);
    strobe(1'b1, 10'h155, 1'b0, 1'b0);
    shadow = 10'h155;
    chk_bytes("R5 store after release");
  endtask

  task automatic t_hi_only();
    strobe(1'b0, 10'h0, 1'b0, 1'b1);
    strobe(1'b1, 10'h3FF, 1'b0, 1'b0);
    shadow = 10'h3FF;
    chk_bytes("R7 high read alone");
  endtask

  task automatic t_same_cycle();
    strobe(1'b1, 10'h001, 1'b1, 1'b0);
    chk("R9 done", {31'h0, done_o}, 32'h1);
    chk_bytes("R9 coincident discard");
    strobe(1'b1, 10'h002, 1'b0, 1'b1);
    chk_bytes("R4 discard during release cycle");
    strobe(1'b1, 10'h003, 1'b0, 1'b0);
    shadow = 10'h003;
    chk_bytes("R5 store after release");
    strobe(1'b0, 10'h0, 1'b1, 1'b1);
    strobe(1'b1, 10'h1E7, 1'b0, 1'b0);
    shadow = 10'h1E7;
    chk_bytes("R5 coincident reads release");
  endtask

  task automatic t_sweep();
    for (int k = 0; k < 6; k++) begin
      logic [9:0] v;
      v = 10'((k * 173 + 37) % 1024);
      fmt_left_i = k[0];
      strobe(1'b1, v, 1'b0, 1'b0);
      shadow = v;
      chk_bytes(k[0] ? "R2 sweep" : "R1 sweep");
    end
    fmt_left_i = 1'b0;
  endtask

  initial begin
    res_vld_i = 0; res_i = 0; fmt_left_i = 0; rd_lo_i = 0; rd_hi_i = 0;
    shadow = 0;
    rst_n = 1'b0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    repeat (3) @(negedge clk);
    t_reset();
    t_right();
    t_left();
    t_lock();
    t_hi_only();
    t_same_cycle();
    t_sweep();
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    #200000;
    total++; bad++;
    $display("FAIL watchdog actual=running expected=finished");
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule